// File: doc/BRIEF.md
# Memory Security Region Filter

The filter sits beside a memory port and classifies every access as allowed or denied. Software defines up to eight protected address windows through a small word-addressed register file. Each window has a first and a last megabyte, and both ends are included. A control word enables each window separately. It also protects all memory that lies outside every window, and it holds a global bypass that turns protection off.

On the access side a request presents an address and a secure attribute. One clock later the block returns a registered verdict. Secure requests are always allowed. A non-secure request is refused when it falls into protected memory. Every register write carries its own bit-enable mask, so a single control bit can be changed without reading the register first.

Top module: `mem_region_filter`

## Requirements
- R1: After reset every register reads as zero and every access, secure or not, is allowed.
- R2: Register index r (0..7) holds the first megabyte of window r, index r+8 holds its last megabyte, and index 16 is the control word; the byte address on the register port is index*4. A read returns the stored 16 bits in rdata[15:0] with rdata[31:16] zero, one cycle after the read strobe. An index above 16 reads zero and ignores writes.
- R3: A write changes only the data bits wdata[15:0] whose mask bit wdata[31:16] is 1; a zero mask leaves the register unchanged.
- R4: Window r contains an address when first_r <= addr[31:20] <= last_r, both ends included; address bits [19:0] take no part in the compare.
- R5: Control bit r (0..7) set to 1 protects window r; with all control bits 8:0 clear, nothing is protected.
- R6: Control bit 8 set to 1 protects every address that lies inside none of the eight windows, whether those windows are enabled or not.
- R7: Control bit 9 set to 1 allows every access whatever the other settings.
- R8: An access with the secure attribute set is always allowed.
- R9: Overlapping windows combine by OR: one enabled window that contains the address is enough to deny a non-secure access.
- R10: resp_valid and resp_allow are registered and appear one cycle after acc_valid; an access in the same cycle as a register write is judged on the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW (7) | Register byte address, index*4 |
| reg_wdata | input | 32 | Mask in [31:16], data in [15:0] |
| reg_rdata | output | 32 | Registered read data |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W (32) | Access address |
| acc_secure | input | 1 | 1 = secure master |
| resp_valid | output | 1 | Verdict valid, one cycle after acc_valid |
| resp_allow | output | 1 | 1 = access allowed |

## Verification
A register write and an access can land in the same clock edge. The verdict must then come from the settings that were in force before the write. The bench provokes this by writing the bit that enables a window in the same cycle as a non-secure access inside that window. It expects an allow for that access and a deny for the identical access on the next cycle. The random phase also mixes writes and accesses freely, and it computes every expected verdict from a bench model taken before that cycle's write is applied.

// File: rtl/msf_pkg.sv
package msf_pkg;
  typedef logic [15:0] half_t;

  // Merge masked data into the old value: set mask bits take new data
  function automatic half_t masked_merge(half_t old_v, half_t mask, half_t data);
    return (old_v & ~mask) | (data & mask);
  endfunction
endpackage

// File: rtl/msf_regfile.sv
module msf_regfile
  import msf_pkg::*;
#(
  parameter int NUM_RGN = 8,
  parameter int REG_AW  = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic                      rd,
  input  logic [REG_AW-1:0]         addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic [NUM_RGN-1:0][15:0]  first_mb,
  output logic [NUM_RGN-1:0][15:0]  last_mb,
  output logic [15:0]               ctrl
);
  localparam int IDX_W    = REG_AW - 2;
  localparam int CTRL_IDX = 2 * NUM_RGN;

  logic [IDX_W-1:0] idx;
  half_t            mask_h, data_h, rd_val;

  assign idx    = addr[REG_AW-1:2];
  assign mask_h = wdata[31:16];
  assign data_h = wdata[15:0];

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        first_mb[r] <= '0;
        last_mb[r]  <= '0;
      end else if (wr) begin
        if (idx == IDX_W'(r))
          first_mb[r] <= masked_merge(first_mb[r], mask_h, data_h);
        if (idx == IDX_W'(r + NUM_RGN))
          last_mb[r] <= masked_merge(last_mb[r], mask_h, data_h);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctrl <= '0;
    else if (wr && idx == IDX_W'(CTRL_IDX))
      ctrl <= masked_merge(ctrl, mask_h, data_h);
  end

  always_comb begin
    rd_val = '0;
    for (int r = 0; r < NUM_RGN; r++) begin
      if (idx == IDX_W'(r))           rd_val = first_mb[r];
      if (idx == IDX_W'(r + NUM_RGN)) rd_val = last_mb[r];
    end
    if (idx == IDX_W'(CTRL_IDX)) rd_val = ctrl;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= {16'h0000, rd_val};
  end
endmodule

// File: rtl/msf_window.sv
module msf_window #(
  parameter int NUM_RGN = 8
) (
  input  logic [15:0]               mb,
  input  logic [NUM_RGN-1:0][15:0]  first_mb,
  input  logic [NUM_RGN-1:0][15:0]  last_mb,
  output logic [NUM_RGN-1:0]        hit
);
  for (genvar r = 0; r < NUM_RGN; r++) begin : g_cmp
    assign hit[r] = (first_mb[r] <= mb) && (mb <= last_mb[r]);
  end
endmodule

// File: rtl/mem_region_filter.sv
module mem_region_filter #(
  parameter int NUM_RGN   = 8,
  parameter int ADDR_W    = 32,
  parameter int GRAIN_LG2 = 20,
  parameter int REG_AW    = $clog2(2 * NUM_RGN + 1) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_secure,
  output logic              resp_valid,
  output logic              resp_allow
);
  localparam int MB_W       = ADDR_W - GRAIN_LG2;
  localparam int REST_BIT   = NUM_RGN;
  localparam int BYPASS_BIT = NUM_RGN + 1;

  logic [NUM_RGN-1:0][15:0] first_mb, last_mb;
  logic [15:0]              ctrl_word;
  logic [NUM_RGN-1:0]       hit;
  logic [15:0]              acc_mb;
  logic                     deny;

  msf_regfile #(.NUM_RGN(NUM_RGN), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .first_mb(first_mb), .last_mb(last_mb), .ctrl(ctrl_word)
  );

  assign acc_mb = 16'(acc_addr[ADDR_W-1:GRAIN_LG2]);

  msf_window #(.NUM_RGN(NUM_RGN)) u_win (
    .mb(acc_mb), .first_mb(first_mb), .last_mb(last_mb), .hit(hit)
  );

  always_comb begin
    deny = (|(hit & ctrl_word[NUM_RGN-1:0])) ||
           (!(|hit) && ctrl_word[REST_BIT]);
    if (acc_secure || ctrl_word[BYPASS_BIT])
      deny = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b1;
    end else begin
      resp_valid <= acc_valid;
      if (acc_valid)
        resp_allow <= !deny;
    end
  end
endmodule

// File: rtl/msf_checker.sv
module msf_checker #(
  parameter int NUM_RGN = 8,
  parameter int REG_AW  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              acc_valid,
  input logic              acc_secure,
  input logic              resp_valid,
  input logic              resp_allow,
  input logic [15:0]       ctrl_word
);
  localparam int CTRL_IDX = 2 * NUM_RGN;
  logic rst_d;

  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d === 1'b1 && rst === 1'b0)
      assert_reset_clear_R1: assert (ctrl_word == 16'h0 && !resp_valid);
  end

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rd && (int'(reg_addr[REG_AW-1:2]) > CTRL_IDX) |=> reg_rdata == 32'h0);

  assert_mask_zero_R3: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_wdata[31:16] == 16'h0 |=> $stable(ctrl_word));

  assert_noprot_allow_R5: assert property (@(posedge clk) disable iff (rst)
    acc_valid && ctrl_word[NUM_RGN:0] == '0 |=> resp_allow);

  assert_bypass_allow_R7: assert property (@(posedge clk) disable iff (rst)
    acc_valid && ctrl_word[NUM_RGN+1] |=> resp_allow);

  assert_secure_allow_R8: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_secure |=> resp_allow);

  assert_resp_follows_R10: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> resp_valid);

  assert_resp_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !resp_valid);
endmodule

bind mem_region_filter msf_checker #(.NUM_RGN(NUM_RGN), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
  .acc_secure(acc_secure), .resp_valid(resp_valid), .resp_allow(resp_allow),
  .ctrl_word(ctrl_word)
);

// File: tb/tb_mem_region_filter.sv
module tb_mem_region_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0, acc_secure = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        resp_valid, resp_allow;

  int checks = 0, errors = 0;
  logic [15:0] mreg [0:16];

  always #5 clk = ~clk;

  mem_region_filter dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_secure(acc_secure),
    .resp_valid(resp_valid), .resp_allow(resp_allow)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_allow(logic [31:0] a, logic s);
    logic [15:0] mb;
    logic any_hit, deny;
    mb = {4'h0, a[31:20]};
    any_hit = 1'b0;
    deny = 1'b0;
    for (int r = 0; r < 8; r++)
      if (mreg[r] <= mb && mb <= mreg[r+8]) begin
        any_hit = 1'b1;
        if (mreg[16][r]) deny = 1'b1;
      end
    if (!any_hit && mreg[16][8]) deny = 1'b1;
    if (s || mreg[16][9]) deny = 1'b0;
    return !deny;
  endfunction

  function automatic void model_wr(int idx, logic [15:0] m, logic [15:0] d);
    if (idx <= 16) mreg[idx] = (mreg[idx] & ~m) | (d & m);
  endfunction

  task automatic do_wr(int idx, logic [15:0] m, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = 7'(idx * 4); reg_wdata = {m, d};
    @(negedge clk);
    reg_wr = 1'b0;
    model_wr(idx, m, d);
  endtask

  task automatic do_rd(int idx, string req);
    logic [31:0] e;
    e = (idx <= 16) ? {16'h0, mreg[idx]} : 32'h0;
    reg_rd = 1'b1; reg_addr = 7'(idx * 4);
    @(negedge clk);
    reg_rd = 1'b0;
    chk(reg_rdata == e, req, reg_rdata, e);
  endtask

  task automatic do_acc(logic [31:0] a, logic s, string req);
    logic e;
    e = exp_allow(a, s);
    acc_valid = 1'b1; acc_addr = a; acc_secure = s;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(resp_valid && resp_allow == e, req, {resp_valid, resp_allow}, {1'b1, e});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    finish_run();
  end

  initial begin
    logic e;
    void'($urandom(32'd4711));
    for (int i = 0; i <= 16; i++) mreg[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!resp_valid, "R10 idle after reset", {31'h0, resp_valid}, 32'h0);

    // R1: reset contents and open access
    for (int i = 0; i <= 16; i++) do_rd(i, "R1 reset register value");
    do_acc(32'h0000_0000, 1'b0, "R1 reset access low");
    do_acc(32'hFFF0_0000, 1'b0, "R1 reset access high");

    // R4/R5: window 0 covers megabytes 0..31
    do_wr(8, 16'hFFFF, 16'd31);
    do_wr(16, 16'h0001, 16'h0001);
    do_rd(8, "R2 last of window 0 at index 8");
    do_acc(32'h01FF_FFFF, 1'b0, "R4 inclusive last megabyte denied");
    do_acc(32'h0200_0000, 1'b0, "R4 one past last allowed");
    do_acc(32'h0000_0123, 1'b1, "R8 secure inside window allowed");
    // single-megabyte window: first=last=0
    do_wr(8, 16'hFFFF, 16'd0);
    do_acc(32'h000F_FFFF, 1'b0, "R4 low bits ignored, denied");
    do_acc(32'h0010_0000, 1'b0, "R4 next megabyte allowed");

    // R3: zero mask and partial mask
    do_wr(16, 16'h0000, 16'hFFFF);
    do_rd(16, "R3 zero mask leaves control");
    do_wr(3, 16'h00F0, 16'hABCD);
    do_rd(3, "R3 partial mask merge");

    // R2: unmapped index
    do_wr(20, 16'hFFFF, 16'h1234);
    do_rd(20, "R2 unmapped reads zero");
    do_rd(16, "R2 unmapped write ignored");

    // R9: overlap, window 1 disabled, window 2 enabled
    do_wr(1, 16'hFFFF, 16'd100); do_wr(9, 16'hFFFF, 16'd200);
    do_wr(2, 16'hFFFF, 16'd150); do_wr(10, 16'hFFFF, 16'd250);
    do_wr(3, 16'hFFFF, 16'd900); do_wr(11, 16'hFFFF, 16'd900);
    do_wr(16, 16'h0006, 16'h0004);
    do_acc(32'h0A00_0000, 1'b0, "R9 overlap enabled window denies");
    do_acc(32'h0780_0000, 1'b0, "R9 disabled only window allows");

    // R6: catch-all
    do_wr(16, 16'h0100, 16'h0100);
    do_acc(32'h3000_0000, 1'b0, "R6 outside all windows denied");
    do_acc(32'h0780_0000, 1'b0, "R6 inside disabled window allowed");
    do_acc(32'h3000_0000, 1'b1, "R8 secure outside allowed");

    // R7: bypass
    do_wr(16, 16'h0200, 16'h0200);
    do_acc(32'h3000_0000, 1'b0, "R7 bypass allows catch-all");
    do_acc(32'h0A00_0000, 1'b0, "R7 bypass allows window");
    do_wr(16, 16'hFFFF, 16'h0000);

    // R10: write and access in the same cycle
    e = exp_allow(32'h0A00_0000, 1'b0);
    reg_wr = 1'b1; reg_addr = 7'(16 * 4); reg_wdata = {16'h0004, 16'h0004};
    acc_valid = 1'b1; acc_addr = 32'h0A00_0000; acc_secure = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0; acc_valid = 1'b0;
    chk(resp_valid && resp_allow == e, "R10 same-cycle uses old settings",
        {resp_valid, resp_allow}, {1'b1, e});
    model_wr(16, 16'h0004, 16'h0004);
    do_acc(32'h0A00_0000, 1'b0, "R10 next cycle uses new settings");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op, idx;
      op = int'($urandom_range(0, 9));
      if (op < 3) begin
        idx = int'($urandom_range(0, 16));
        if (idx == 16)
          do_wr(idx, 16'($urandom), 16'($urandom) & 16'h03FF);
        else
          do_wr(idx, 16'($urandom), 16'($urandom_range(0, 63)));
      end else if (op == 3) begin
        do_rd(int'($urandom_range(0, 18)), "R2 random read");
      end else if (op == 4) begin
        idx = int'($urandom_range(0, 16));
        e = exp_allow(32'($urandom_range(0, 70)) << 20, 1'b0);
        acc_addr = (32'($urandom_range(0, 70)) << 20) | 32'($urandom_range(0, 32'hFFFFF));
        e = exp_allow(acc_addr, 1'b0);
        reg_wr = 1'b1; reg_addr = 7'(idx * 4);
        reg_wdata = {16'($urandom), 16'($urandom_range(0, 63))};
        acc_valid = 1'b1; acc_secure = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0; acc_valid = 1'b0;
        chk(resp_valid && resp_allow == e, "R10 random same-cycle",
            {resp_valid, resp_allow}, {1'b1, e});
        model_wr(idx, reg_wdata[31:16], reg_wdata[15:0]);
      end else begin
        do_acc((32'($urandom_range(0, 70)) << 20) | 32'($urandom_range(0, 32'hFFFFF)),
               1'($urandom_range(0, 4) == 0), "R5 random access verdict");
      end
    end
    finish_run();
  end
endmodule